// File: doc/BRIEF.md
# In-Place Reversible Ripple Adder

This block is a combinational model of an N-bit adder built only from reversible gate primitives: controlled-NOT, Toffoli, Peres, TR and plain inversion. The operands, the input carry and one spare top bit sit on a row of bit lines. Six fixed gate passes run over that row, and no helper line is added for any bit position. When the passes finish, the addend lines hold the sum and the spare top line holds its input value XOR the carry-out. Every other line, the augend bits and the input-carry line included, is back at the value it entered with.

The model is used to confirm, bit for bit, that such a gate cascade adds correctly for any width. The reversible passes can then be carried into other reversible arithmetic with confidence. Each pass is a separate piece of logic: an exchange pass that moves augend bits onto addend bits, an upward and a downward chaining pass along the augend lines, and an upward and a downward carry sweep. They are wired in the order the algorithm needs: exchange, chain up, sweep up, sweep down, chain down, exchange.

No clock and no state are involved. The passes are wired stages, not the states of a machine. The outputs follow the inputs through logic only.

Top module: `rev_inplace_adder`

## Requirements
- R1: `sum` equals the low N bits of the unsigned value a + b + cin, for every input combination.
- R2: `z_out` equals `z` XOR the carry-out, where the carry-out is bit N of a + b + cin.
- R3: `a_out` equals `a` for every input combination, and the internal input-carry line ends equal to `cin`.
- R4: With `a` all ones, `b` zero and `cin` = 1, the carry ripples through every position: `sum` is zero and `z_out` is the inverse of `z`.
- R5: The outputs depend only on the present inputs. Applying the same input again, after other inputs, gives the same outputs.
- R6: The construction is correct for every N of 1 or more. The narrowest case, N = 1, also gives R1 to R3 for all of its 16 input combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Augend bits; bit i is line i of the augend row |
| b | input | N | Addend bits; these lines receive the sum |
| cin | input | 1 | Input carry, on the line just below augend bit 0 |
| z | input | 1 | Spare top line, either value allowed |
| a_out | output | N | Augend lines after the cascade, equal to `a` |
| sum | output | N | Addend lines after the cascade, holding the sum bits |
| z_out | output | 1 | Top line after the cascade, `z` XOR carry-out |

## Verification
The assertions compare the final lines with the arithmetic sum of the inputs. They therefore assume that every input is a defined 0 or 1 when the logic settles. The bench drives each input from a loop counter, one whole vector per clock period, so no input is ever unknown or changing at the moment of comparison. Sweeping the counter over every combination of a, b, cin and z puts both values of the spare line and both carry polarities through every chaining pass. The narrow N = 1 instance is swept in the same way, so the corner where the Peres gate's control is the input-carry line itself is covered.

// File: rtl/rev_adder_pkg.sv
package rev_adder_pkg;

    // Variants of the two-input exchange passes.
    typedef enum logic [1:0] {
        LINK_ONTO_ADDEND = 2'd0,  // addend line ^= matching augend line
        LINK_CHAIN_UP    = 2'd1,  // lower augend line ^= next higher, from bottom
        LINK_CHAIN_DOWN  = 2'd2   // lower augend line ^= next higher, from top
    } link_mode_e;

    // Direction of a three-input carry sweep.
    typedef enum logic {
        SWEEP_RISE = 1'b0,
        SWEEP_FALL = 1'b1
    } sweep_dir_e;

    // Three lines handed to a three-input gate.
    typedef struct packed {
        logic ctl;
        logic mid;
        logic tgt;
    } trio_t;

    // Toffoli: target flips when both controls are one.
    function automatic trio_t gate_toffoli(input trio_t t);
        trio_t r;
        r     = t;
        r.tgt = t.tgt ^ (t.ctl & t.mid);
        return r;
    endfunction

    // Peres: Toffoli followed by a controlled-NOT onto the middle line.
    function automatic trio_t gate_peres(input trio_t t);
        trio_t r;
        r.ctl = t.ctl;
        r.mid = t.ctl ^ t.mid;
        r.tgt = t.tgt ^ (t.ctl & t.mid);
        return r;
    endfunction

    // TR: target flips when control is one and middle is zero,
    // middle takes control XOR middle.
    function automatic trio_t gate_tr(input trio_t t);
        trio_t r;
        r.ctl = t.ctl;
        r.mid = t.ctl ^ t.mid;
        r.tgt = t.tgt ^ (t.ctl & ~t.mid);
        return r;
    endfunction

endpackage

// File: rtl/rev_link_pass.sv
// Controlled-NOT passes. Augend row index k holds line A(k-1):
// k = 0 is the carry line, k = 1..N the augend bits, k = N+1 the top line.
module rev_link_pass
    import rev_adder_pkg::*;
#(
    parameter int         N    = 4,
    parameter link_mode_e MODE = LINK_ONTO_ADDEND
) (
    input  logic [N+1:0] row_in,
    input  logic [N-1:0] add_in,
    output logic [N+1:0] row_out,
    output logic [N-1:0] add_out
);

    localparam int ROW_W = N + 2;

    generate
        if (MODE == LINK_ONTO_ADDEND) begin : g_onto
            always_comb begin
                row_out = row_in;
                for (int i = 0; i < N; i++) begin
                    add_out[i] = add_in[i] ^ row_in[i+1];
                end
            end
        end else if (MODE == LINK_CHAIN_UP) begin : g_up
            // Bottom to top: each target reads a line not yet rewritten,
            // then the top line takes the highest augend bit.
            always_comb begin
                logic [ROW_W-1:0] work;
                work = row_in;
                for (int k = 0; k < N; k++) begin
                    work[k] = work[k] ^ work[k+1];
                end
                work[N+1] = work[N+1] ^ work[N];
                row_out = work;
                add_out = add_in;
            end
        end else begin : g_down
            // Top to bottom: each target reads the line just rewritten.
            always_comb begin
                logic [ROW_W-1:0] work;
                work = row_in;
                for (int k = N - 1; k >= 0; k--) begin
                    work[k] = work[k] ^ work[k+1];
                end
                row_out = work;
                add_out = add_in;
            end
        end
    endgenerate

endmodule

// File: rtl/rev_carry_sweep.sv
// Three-input carry passes over the augend row and the addend lines.
module rev_carry_sweep
    import rev_adder_pkg::*;
#(
    parameter int         N   = 4,
    parameter sweep_dir_e DIR = SWEEP_RISE
) (
    input  logic [N+1:0] row_in,
    input  logic [N-1:0] add_in,
    output logic [N+1:0] row_out,
    output logic [N-1:0] add_out
);

    localparam int ROW_W = N + 2;
    localparam int LOW_N = N - 1;   // addend lines below the top bit position

    generate
        if (DIR == SWEEP_RISE) begin : g_rise
            always_comb begin
                logic [ROW_W-1:0] work;
                logic [N-1:0]     lane;
                trio_t            t;
                work = row_in;
                lane = add_in;
                for (int i = 0; i < LOW_N; i++) begin
                    t = gate_toffoli(trio_t'{work[i], lane[i], work[i+1]});
                    work[i+1] = t.tgt;
                end
                t = gate_peres(trio_t'{work[N-1], lane[N-1], work[N+1]});
                lane[N-1] = t.mid;
                work[N+1] = t.tgt;
                for (int i = 0; i < LOW_N; i++) begin
                    lane[i] = ~lane[i];
                end
                row_out = work;
                add_out = lane;
            end
        end else begin : g_fall
            always_comb begin
                logic [ROW_W-1:0] work;
                logic [N-1:0]     lane;
                trio_t            t;
                work = row_in;
                lane = add_in;
                for (int i = LOW_N - 1; i >= 0; i--) begin
                    t = gate_tr(trio_t'{work[i], lane[i], work[i+1]});
                    lane[i]   = t.mid;
                    work[i+1] = t.tgt;
                end
                for (int i = 0; i < LOW_N; i++) begin
                    lane[i] = ~lane[i];
                end
                row_out = work;
                add_out = lane;
            end
        end
    endgenerate

endmodule

// File: rtl/rev_inplace_adder.sv
module rev_inplace_adder
    import rev_adder_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    input  logic         z,
    output logic [N-1:0] a_out,
    output logic [N-1:0] sum,
    output logic         z_out
);

    localparam int ROW_W = N + 2;

    // Row and addend lines between the six passes.
    logic [ROW_W-1:0] row_s0, row_s1, row_s2, row_s3, row_s4, row_s5, row_s6;
    logic [N-1:0]     add_s0, add_s1, add_s2, add_s3, add_s4, add_s5, add_s6;

    assign row_s0 = {z, a, cin};
    assign add_s0 = b;

    rev_link_pass #(.N(N), .MODE(LINK_ONTO_ADDEND)) u_pass1 (
        .row_in(row_s0), .add_in(add_s0), .row_out(row_s1), .add_out(add_s1));

    rev_link_pass #(.N(N), .MODE(LINK_CHAIN_UP)) u_pass2 (
        .row_in(row_s1), .add_in(add_s1), .row_out(row_s2), .add_out(add_s2));

    rev_carry_sweep #(.N(N), .DIR(SWEEP_RISE)) u_pass3 (
        .row_in(row_s2), .add_in(add_s2), .row_out(row_s3), .add_out(add_s3));

    rev_carry_sweep #(.N(N), .DIR(SWEEP_FALL)) u_pass4 (
        .row_in(row_s3), .add_in(add_s3), .row_out(row_s4), .add_out(add_s4));

    rev_link_pass #(.N(N), .MODE(LINK_CHAIN_DOWN)) u_pass5 (
        .row_in(row_s4), .add_in(add_s4), .row_out(row_s5), .add_out(add_s5));

    rev_link_pass #(.N(N), .MODE(LINK_ONTO_ADDEND)) u_pass6 (
        .row_in(row_s5), .add_in(add_s5), .row_out(row_s6), .add_out(add_s6));

    assign a_out = row_s6[N:1];
    assign sum   = add_s6;
    assign z_out = row_s6[N+1];

    // Arithmetic view of the inputs, used only by the checks below.
    logic [N:0] arith;
    assign arith = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};

    always_comb begin
        assert_sum_R1: assert (add_s6 == arith[N-1:0])
            else $error("R1 sum lines disagree with a+b+cin");
        assert_top_line_R2: assert (row_s6[N+1] == (z ^ arith[N]))
            else $error("R2 top line is not z xor carry-out");
        assert_augend_R3: assert (row_s6[N:1] == a)
            else $error("R3 augend lines not restored");
        assert_carry_line_R3: assert (row_s6[0] == cin)
            else $error("R3 input-carry line not restored");
        // After the rising sweep the top line already holds z xor carry-out.
        assert_mid_top_R2: assert (row_s3[N+1] == (z ^ arith[N]))
            else $error("R2 top line wrong after rising sweep");
    end

endmodule

// File: tb/rev_inplace_adder_test.sv
module rev_inplace_adder_test;

    localparam int N  = 4;
    localparam int NW = 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic [N-1:0] a, b, a_out, sum;
    logic         cin, z, z_out;

    logic [NW-1:0] na, nb, na_out, nsum;
    logic          ncin, nz, nz_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    rev_inplace_adder #(.N(N)) uut (
        .a(a), .b(b), .cin(cin), .z(z),
        .a_out(a_out), .sum(sum), .z_out(z_out));

    rev_inplace_adder #(.N(NW)) uut_narrow (
        .a(na), .b(nb), .cin(ncin), .z(nz),
        .a_out(na_out), .sum(nsum), .z_out(nz_out));

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (a=%0d b=%0d cin=%0d z=%0d)",
                     req, actual, expected, a, b, cin, z);
        end
    endtask

    // Behavioural reference with plain integers.
    task automatic check_wide(input string tag);
        int total;
        total = int'(a) + int'(b) + int'(cin);
        check({"R1 ", tag}, int'(sum), total % (1 << N));
        check({"R2 ", tag}, int'(z_out), int'(z) ^ (total >> N));
        check({"R3 ", tag}, int'(a_out), int'(a));
    endtask

    task automatic apply(input int av, input int bv, input int cv, input int zv);
        @(negedge clk);
        a   = N'(av);
        b   = N'(bv);
        cin = cv[0];
        z   = zv[0];
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; cin = 1'b0; z = 1'b0;
        na = '0; nb = '0; ncin = 1'b0; nz = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // Initial state: all-zero inputs give all-zero outputs.
        check("R1 initial sum", int'(sum), 0);
        check("R2 initial top", int'(z_out), 0);
        check("R3 initial augend", int'(a_out), 0);

        // R1 R2 R3: every combination of a, b, cin, z.
        for (int v = 0; v < (1 << (2 * N + 2)); v++) begin
            apply(v & ((1 << N) - 1), (v >> N) & ((1 << N) - 1),
                  (v >> (2 * N)) & 1, (v >> (2 * N + 1)) & 1);
            check_wide("sweep");
        end

        // R4: full ripple, with both values of the top line.
        for (int zv = 0; zv < 2; zv++) begin
            apply((1 << N) - 1, 0, 1, zv);
            check("R4 ripple sum", int'(sum), 0);
            check("R4 ripple top", int'(z_out), 1 - zv);
        end

        // R5: same vector after unrelated ones gives the same result.
        apply(5, 11, 1, 0);
        check_wide("R5 first");
        apply(15, 15, 1, 1);
        apply(0, 9, 0, 1);
        apply(5, 11, 1, 0);
        check("R5 repeat sum", int'(sum), 1);
        check("R5 repeat top", int'(z_out), 1);

        // R6: narrow instance, all 16 combinations.
        for (int v = 0; v < 16; v++) begin
            int total;
            @(negedge clk);
            na   = v[0];
            nb   = v[1];
            ncin = v[2];
            nz   = v[3];
            @(posedge clk);
            #1;
            total = v[0] + v[1] + v[2];
            check("R6 narrow sum", int'(nsum), total & 1);
            check("R6 narrow top", int'(nz_out), v[3] ^ (total >> 1));
            check("R6 narrow augend", int'(na_out), v[0]);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule